// File: doc/BRIEF.md
# Device Error Signaling Controller

This block sits beside the error detectors of a PCIe-style function. Each detected error arrives as a single event on a valid/ready input. The event carries a status bit vector, a correctable flag, a flag saying the error may be treated as advisory, and the 16-bit ID of the requester it concerns.

For each event the block does the following:
- rejects the event unless exactly one supported status bit remains;
- settles the event's severity;
- sets the sticky device, correctable and uncorrectable status bits;
- applies the mask registers;
- decides whether to send an error message upstream, as a one-cycle pulse with a severity code and the source ID.

Header logging is handed to a separate logger through a request strobe. When the logger reports that its storage is full, the block processes a second, internally generated correctable event in the following cycle. That event records the header-log overflow.

The control, mask and severity fields come in as plain ports. Their register decoding lives elsewhere. Sticky status bits are cleared through write-one-to-clear strobe vectors.

Top module: `err_signal_ctrl`

## Requirements
- R1: Supported bits are the only ones considered. On the correctable class these are bits 0, 6, 7, 8, 12, 13, 14 and 15. On the uncorrectable class they are bits 4, 5 and 12 through 25. An event whose supported bits are zero, or more than one, is accepted but changes no status, requests no logging and sends no message.
- R2: When `sev_reg_use` is low, uncorrectable bits 4, 5, 13, 17, 18 and 22 are fatal and every other uncorrectable bit is non-fatal. When `sev_reg_use` is high, the event's bit in `unc_sev` decides: 1 means fatal.
- R3: A correctable event sets `dev_sta[0]` and its bit in `cor_sta`. It sends a message with severity code 2'b01 only when its `cor_mask` bit is clear and `cor_rpt_en` is high.
- R4: A non-advisory uncorrectable event sets `dev_sta[2]` if fatal or `dev_sta[1]` if non-fatal, and always sets its bit in `unc_sta`. If its `unc_mask` bit is set, there is no logging and no message.
- R5: An unmasked non-advisory uncorrectable event pulses `log_req` with `log_bit` equal to the one-hot status bit. A fatal message (code 2'b11) needs `serr_en` or `fatal_rpt_en`. A non-fatal message (code 2'b10) needs `serr_en` or `nonfatal_rpt_en`.
- R6: The unsupported-request error is uncorrectable bit 20 and also sets `dev_sta[3]`. On the uncorrectable path, its message is dropped when `ur_rpt_en` and `serr_en` are both low. On the advisory path it is dropped whenever `ur_rpt_en` is low.
- R7: A non-fatal uncorrectable event with `ev_advisory` high is treated as follows:
  - it sets `dev_sta[0]`, correctable bit 13, and its own bit in `unc_sta`;
  - if `cor_mask[13]` is set, nothing further happens;
  - otherwise logging is requested only when its `unc_mask` bit is clear;
  - a message with code 2'b01 is sent when `cor_rpt_en` is high.
- R8: A logging request made while `log_full` is high starts an overflow follow-up. In the next cycle the block itself processes correctable bit 15 under the R3 rules, using the original source ID. `ev_ready` is low in that cycle only.
- R9: An event accepted at a clock edge shows its status, message and logging results right after that edge. `msg_valid` and `log_req` stay high for one cycle per event.
- R10: After reset all outputs are zero except `ev_ready`, which is high. A `clr_*` bit clears its sticky status bit, but a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Error event present |
| ev_ready | output | 1 | Event can be accepted |
| ev_status | input | 32 | Status bit vector of the event |
| ev_correctable | input | 1 | Event belongs to the correctable class |
| ev_advisory | input | 1 | Non-fatal event may be treated as advisory |
| ev_source | input | 16 | Requester ID of the event |
| serr_en | input | 1 | System error reporting enable |
| cor_rpt_en | input | 1 | Correctable reporting enable |
| nonfatal_rpt_en | input | 1 | Non-fatal reporting enable |
| fatal_rpt_en | input | 1 | Fatal reporting enable |
| ur_rpt_en | input | 1 | Unsupported-request reporting enable |
| sev_reg_use | input | 1 | Take severity from unc_sev instead of defaults |
| unc_sev | input | 32 | Per-bit uncorrectable severity, 1 = fatal |
| unc_mask | input | 32 | Uncorrectable mask |
| cor_mask | input | 16 | Correctable mask |
| log_full | input | 1 | Logger cannot take a request this cycle |
| clr_dev | input | 4 | Write-one-to-clear for dev_sta |
| clr_cor | input | 16 | Write-one-to-clear for cor_sta |
| clr_unc | input | 32 | Write-one-to-clear for unc_sta |
| dev_sta | output | 4 | {UR, fatal, non-fatal, correctable} detected |
| cor_sta | output | 16 | Sticky correctable status |
| unc_sta | output | 32 | Sticky uncorrectable status |
| msg_valid | output | 1 | Error message pulse |
| msg_sev | output | 2 | 01 correctable, 10 non-fatal, 11 fatal |
| msg_source | output | 16 | Source ID of the message |
| log_req | output | 1 | Header logging request pulse |
| log_bit | output | 32 | One-hot status bit to log |
| log_source | output | 16 | Source ID to log |

## Verification
Random events mix four kinds of status vector:
- single supported bits, which exercise the severity and masking paths;
- single unsupported bits, which must fall into rejection;
- dense random words, which carry several bits at once and must also be rejected;
- zero.

Enables, masks, severity selection and logger-full are drawn fresh per event, so the fatal, non-fatal, advisory and unsupported-request branches meet every enable combination. Directed cases separate the default severity table from the severity-register override. They also show that `serr_en` rescues an unsupported-request message on the uncorrectable path but not on the advisory path, and that the overflow follow-up runs in the cycle after the original event.

// File: rtl/err_sig_pkg.sv
package err_sig_pkg;
  localparam int COR_W = 16;
  localparam int UNC_W = 32;
  localparam int DEV_W = 4;

  localparam logic [COR_W-1:0] COR_SUPPORTED = 16'hF1C1;
  localparam logic [UNC_W-1:0] UNC_SUPPORTED = 32'h03FF_F030;
  localparam logic [UNC_W-1:0] UNC_DEF_FATAL = 32'h0046_2030;
  localparam int UR_IDX  = 20;
  localparam int ADV_IDX = 13;
  localparam int HLO_IDX = 15;

  localparam int DEV_COR = 0;
  localparam int DEV_NF  = 1;
  localparam int DEV_FAT = 2;
  localparam int DEV_UR  = 3;

  typedef enum logic [1:0] {
    SEV_NONE     = 2'b00,
    SEV_COR      = 2'b01,
    SEV_NONFATAL = 2'b10,
    SEV_FATAL    = 2'b11
  } sev_e;

  typedef struct packed {
    logic             valid;
    logic             corr;
    logic             fatal;
    logic             ur;
    logic             adv;
    logic [UNC_W-1:0] bits;
  } evclass_t;
endpackage

// File: rtl/err_classify.sv
module err_classify
  import err_sig_pkg::*;
(
  input  logic [UNC_W-1:0] status,
  input  logic             correctable,
  input  logic             advisory,
  input  logic             sev_reg_use,
  input  logic [UNC_W-1:0] unc_sev,
  output evclass_t         cls
);
  localparam logic [UNC_W-1:0] COR_SUP_WIDE = {{(UNC_W-COR_W){1'b0}}, COR_SUPPORTED};

  logic [UNC_W-1:0] kept;
  logic             fatal_c;

  always_comb begin
    kept    = status & (correctable ? COR_SUP_WIDE : UNC_SUPPORTED);
    fatal_c = !correctable &&
              (sev_reg_use ? |(kept & unc_sev) : |(kept & UNC_DEF_FATAL));
    cls.bits  = kept;
    cls.valid = (kept != '0) && ((kept & (kept - 1'b1)) == '0);
    cls.corr  = correctable;
    cls.fatal = fatal_c;
    cls.ur    = !correctable && (kept == (UNC_W'(1) << UR_IDX));
    cls.adv   = !correctable && !fatal_c && advisory;
  end
endmodule

// File: rtl/err_route.sv
module err_route
  import err_sig_pkg::*;
(
  input  evclass_t         cls,
  input  logic             serr_en,
  input  logic             cor_rpt_en,
  input  logic             nonfatal_rpt_en,
  input  logic             fatal_rpt_en,
  input  logic             ur_rpt_en,
  input  logic [UNC_W-1:0] unc_mask,
  input  logic [COR_W-1:0] cor_mask,
  output logic [DEV_W-1:0] set_dev,
  output logic [COR_W-1:0] set_cor,
  output logic [UNC_W-1:0] set_unc,
  output logic             want_log,
  output logic             want_msg,
  output sev_e             sev
);
  logic unc_masked;
  logic cor_masked;

  always_comb begin
    unc_masked = |(cls.bits & unc_mask);
    cor_masked = |(cls.bits[COR_W-1:0] & cor_mask);
    set_dev  = '0;
    set_cor  = '0;
    set_unc  = '0;
    want_log = 1'b0;
    want_msg = 1'b0;
    sev      = SEV_NONE;
    if (cls.valid) begin
      if (cls.corr) begin
        set_dev[DEV_COR] = 1'b1;
        set_cor          = cls.bits[COR_W-1:0];
        sev              = SEV_COR;
        want_msg         = !cor_masked && cor_rpt_en;
      end else if (cls.adv) begin
        set_dev[DEV_COR] = 1'b1;
        set_dev[DEV_UR]  = cls.ur;
        set_cor[ADV_IDX] = 1'b1;
        set_unc          = cls.bits;
        sev              = SEV_COR;
        if (!cor_mask[ADV_IDX]) begin
          want_log = !unc_masked;
          want_msg = cor_rpt_en && !(cls.ur && !ur_rpt_en);
        end
      end else begin
        set_dev[DEV_FAT] = cls.fatal;
        set_dev[DEV_NF]  = !cls.fatal;
        set_dev[DEV_UR]  = cls.ur;
        set_unc          = cls.bits;
        sev              = cls.fatal ? SEV_FATAL : SEV_NONFATAL;
        if (!unc_masked) begin
          want_log = 1'b1;
          want_msg = !(cls.ur && !ur_rpt_en && !serr_en) &&
                     (serr_en || (cls.fatal ? fatal_rpt_en : nonfatal_rpt_en));
        end
      end
    end
  end
endmodule

// File: rtl/err_signal_ctrl.sv
module err_signal_ctrl
  import err_sig_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [31:0]      ev_status,
  input  logic             ev_correctable,
  input  logic             ev_advisory,
  input  logic [SRC_W-1:0] ev_source,
  input  logic             serr_en,
  input  logic             cor_rpt_en,
  input  logic             nonfatal_rpt_en,
  input  logic             fatal_rpt_en,
  input  logic             ur_rpt_en,
  input  logic             sev_reg_use,
  input  logic [31:0]      unc_sev,
  input  logic [31:0]      unc_mask,
  input  logic [15:0]      cor_mask,
  input  logic             log_full,
  input  logic [3:0]       clr_dev,
  input  logic [15:0]      clr_cor,
  input  logic [31:0]      clr_unc,
  output logic [3:0]       dev_sta,
  output logic [15:0]      cor_sta,
  output logic [31:0]      unc_sta,
  output logic             msg_valid,
  output logic [1:0]       msg_sev,
  output logic [SRC_W-1:0] msg_source,
  output logic             log_req,
  output logic [31:0]      log_bit,
  output logic [SRC_W-1:0] log_source
);
  localparam logic [UNC_W-1:0] HLO_EVENT = UNC_W'(1) << HLO_IDX;

  logic             ovf_pend_q, ovf_pend_d;
  logic [SRC_W-1:0] ovf_src_q;
  logic             bad_q, bad_d;
  logic [DEV_W-1:0] dev_q, dev_d;
  logic [COR_W-1:0] cor_q, cor_d;
  logic [UNC_W-1:0] unc_q, unc_d;
  logic             msgv_q, logv_q;
  sev_e             sev_q;
  logic [SRC_W-1:0] msg_src_q, log_src_q;
  logic [UNC_W-1:0] log_bit_q;

  logic             fire;
  logic [UNC_W-1:0] in_status;
  logic             in_corr, in_adv;
  logic [SRC_W-1:0] in_src;
  evclass_t         cls;
  logic [DEV_W-1:0] set_dev;
  logic [COR_W-1:0] set_cor;
  logic [UNC_W-1:0] set_unc;
  logic             want_log, want_msg;
  sev_e             sev_c;

  // The internal overflow event takes the slot in the cycle after its cause.
  always_comb begin
    fire      = ovf_pend_q || (ev_valid && ev_ready);
    in_status = ovf_pend_q ? HLO_EVENT : ev_status;
    in_corr   = ovf_pend_q || ev_correctable;
    in_adv    = !ovf_pend_q && ev_advisory;
    in_src    = ovf_pend_q ? ovf_src_q : ev_source;
  end

  err_classify u_classify (
    .status      (in_status),
    .correctable (in_corr),
    .advisory    (in_adv),
    .sev_reg_use (sev_reg_use),
    .unc_sev     (unc_sev),
    .cls         (cls)
  );

  err_route u_route (
    .cls             (cls),
    .serr_en         (serr_en),
    .cor_rpt_en      (cor_rpt_en),
    .nonfatal_rpt_en (nonfatal_rpt_en),
    .fatal_rpt_en    (fatal_rpt_en),
    .ur_rpt_en       (ur_rpt_en),
    .unc_mask        (unc_mask),
    .cor_mask        (cor_mask),
    .set_dev         (set_dev),
    .set_cor         (set_cor),
    .set_unc         (set_unc),
    .want_log        (want_log),
    .want_msg        (want_msg),
    .sev             (sev_c)
  );

  always_comb begin
    dev_d      = (dev_q & ~clr_dev) | (fire ? set_dev : '0);
    cor_d      = (cor_q & ~clr_cor) | (fire ? set_cor : '0);
    unc_d      = (unc_q & ~clr_unc) | (fire ? set_unc : '0);
    ovf_pend_d = fire && want_log && log_full;
    bad_d      = fire && !cls.valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_pend_q <= 1'b0;
      ovf_src_q  <= '0;
      bad_q      <= 1'b0;
      dev_q      <= '0;
      cor_q      <= '0;
      unc_q      <= '0;
      msgv_q     <= 1'b0;
      logv_q     <= 1'b0;
      sev_q      <= SEV_NONE;
      msg_src_q  <= '0;
      log_src_q  <= '0;
      log_bit_q  <= '0;
    end else begin
      ovf_pend_q <= ovf_pend_d;
      bad_q      <= bad_d;
      dev_q      <= dev_d;
      cor_q      <= cor_d;
      unc_q      <= unc_d;
      msgv_q     <= fire && want_msg;
      logv_q     <= fire && want_log;
      if (ovf_pend_d) ovf_src_q <= in_src;
      if (fire && want_msg) begin
        sev_q     <= sev_c;
        msg_src_q <= in_src;
      end
      if (fire && want_log) begin
        log_bit_q <= cls.bits;
        log_src_q <= in_src;
      end
    end
  end

  assign ev_ready   = !ovf_pend_q;
  assign dev_sta    = dev_q;
  assign cor_sta    = cor_q;
  assign unc_sta    = unc_q;
  assign msg_valid  = msgv_q;
  assign msg_sev    = sev_q;
  assign msg_source = msg_src_q;
  assign log_req    = logv_q;
  assign log_bit    = log_bit_q;
  assign log_source = log_src_q;

  assert_reject_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q |-> (!msg_valid && !log_req));

  assert_cor_msg_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == SEV_COR) |-> dev_sta[DEV_COR]);

  assert_fatal_msg_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == SEV_FATAL) |-> dev_sta[DEV_FAT]);

  assert_log_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    log_req |-> ($countones(log_bit) == 1 && (unc_sta & log_bit) != '0));

  assert_ovf_followup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ready |=> (ev_ready && cor_sta[HLO_IDX]));
endmodule

// File: tb/err_signal_ctrl_tb.sv
module err_signal_ctrl_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, ev_valid, ev_ready, ev_correctable, ev_advisory;
  logic [31:0] ev_status, unc_sev, unc_mask, clr_unc, unc_sta, log_bit;
  logic [15:0] ev_source, cor_mask, clr_cor, cor_sta, msg_source, log_source;
  logic        serr_en, cor_rpt_en, nonfatal_rpt_en, fatal_rpt_en, ur_rpt_en;
  logic        sev_reg_use, log_full, msg_valid, log_req;
  logic [3:0]  clr_dev, dev_sta;
  logic [1:0]  msg_sev;

  err_signal_ctrl u_dut (.*);

  int checks = 0, errors = 0;
  logic [3:0]  m_dev;
  logic [15:0] m_cor;
  logic [31:0] m_unc;
  logic        e_msg, e_log;
  logic [1:0]  e_sev;
  logic [31:0] e_logbit;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit supported(input int i, input bit corr);
    if (corr) return (i == 0 || i == 6 || i == 7 || i == 8 || (i >= 12 && i <= 15));
    return (i == 4 || i == 5 || (i >= 12 && i <= 25));
  endfunction

  function automatic bit def_fatal(input int i);
    return (i == 4 || i == 5 || i == 13 || i == 17 || i == 18 || i == 22);
  endfunction

  task automatic model(input logic [31:0] st, input bit corr, input bit adv);
    int n = 0, idx = 0;
    bit fat, ur;
    e_msg = 0; e_log = 0; e_sev = 2'b00; e_logbit = 0;
    for (int i = 0; i < 32; i++)
      if (st[i] && supported(i, corr)) begin n++; idx = i; end
    if (n != 1) return;
    if (corr) begin
      m_dev[0] = 1; m_cor[idx] = 1; e_sev = 2'b01;
      e_msg = !cor_mask[idx] && cor_rpt_en;
      return;
    end
    fat = sev_reg_use ? unc_sev[idx] : def_fatal(idx);
    ur  = (idx == 20);
    m_unc[idx] = 1;
    if (ur) m_dev[3] = 1;
    if (!fat && adv) begin
      m_dev[0] = 1; m_cor[13] = 1; e_sev = 2'b01;
      if (!cor_mask[13]) begin
        e_log = !unc_mask[idx];
        e_msg = cor_rpt_en && (ur_rpt_en || !ur);
      end
    end else begin
      if (fat) m_dev[2] = 1; else m_dev[1] = 1;
      e_sev = fat ? 2'b11 : 2'b10;
      if (!unc_mask[idx]) begin
        e_log = 1;
        e_msg = (serr_en || (fat ? fatal_rpt_en : nonfatal_rpt_en)) &&
                !(ur && !ur_rpt_en && !serr_en);
      end
    end
    if (e_log) e_logbit = 32'h1 << idx;
  endtask

  task automatic compare(input string req, input logic [15:0] src);
    check(req, "msg_valid", msg_valid, e_msg);
    if (e_msg) begin
      check(req, "msg_sev", msg_sev, e_sev);
      check(req, "msg_source", msg_source, src);
    end
    check(req, "log_req", log_req, e_log);
    if (e_log) begin
      check(req, "log_bit", log_bit, e_logbit);
      check(req, "log_source", log_source, src);
    end
    check(req, "dev_sta", dev_sta, m_dev);
    check(req, "cor_sta", cor_sta, m_cor);
    check(req, "unc_sta", unc_sta, m_unc);
  endtask

  task automatic send(input string req, input logic [31:0] st, input bit corr, input bit adv,
                      input logic [15:0] src, input bit full);
    bit ovf;
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1; ev_status = st; ev_correctable = corr; ev_advisory = adv;
    ev_source = src; log_full = full;
    m_dev = m_dev & ~clr_dev; m_cor = m_cor & ~clr_cor; m_unc = m_unc & ~clr_unc;
    model(st, corr, adv);
    ovf = e_log && full;
    @(negedge clk);
    ev_valid = 0; clr_dev = 0; clr_cor = 0; clr_unc = 0;
    compare(req, src);
    if (ovf) begin
      check("R8", "ev_ready low in follow-up cycle", ev_ready, 0);
      model(32'h8000, 1, 0);
      @(negedge clk);
      compare("R8", src);
      check("R8", "ev_ready back", ev_ready, 1);
    end
  endtask

  task automatic cfg(input bit s, input bit c, input bit nf, input bit f, input bit u);
    serr_en = s; cor_rpt_en = c; nonfatal_rpt_en = nf; fatal_rpt_en = f; ur_rpt_en = u;
  endtask

  logic done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; ev_valid = 0; ev_status = 0; ev_correctable = 0; ev_advisory = 0;
    ev_source = 0; cfg(0, 0, 0, 0, 0); sev_reg_use = 0; unc_sev = 0; unc_mask = 0;
    cor_mask = 0; log_full = 0; clr_dev = 0; clr_cor = 0; clr_unc = 0;
    m_dev = 0; m_cor = 0; m_unc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10", "ev_ready", ev_ready, 1);
    check("R10", "msg_valid", msg_valid, 0);
    check("R10", "log_req", log_req, 0);
    check("R10", "status", {dev_sta, cor_sta, unc_sta}, 0);

    // R1 rejection: zero, two bits, unsupported bit
    cfg(1, 1, 1, 1, 1);
    send("R1", 32'h0, 0, 0, 16'h0101, 0);
    send("R1", 32'h0000_3000, 0, 0, 16'h0102, 0);
    send("R1", 32'h0000_0002, 1, 0, 16'h0103, 0);
    // R2 default severity: bit 4 fatal, bit 12 non-fatal; override
    send("R2", 32'h0000_0010, 0, 0, 16'h0201, 0);
    send("R2", 32'h0000_1000, 0, 0, 16'h0202, 0);
    sev_reg_use = 1; unc_sev = 32'h0000_1000;
    send("R2", 32'h0000_1000, 0, 0, 16'h0203, 0);
    send("R2", 32'h0000_0010, 0, 0, 16'h0204, 0);
    sev_reg_use = 0;
    // R3 correctable masked then enabled
    cor_mask = 16'h0040;
    send("R3", 32'h0000_0040, 1, 0, 16'h0301, 0);
    cor_mask = 0;
    send("R3", 32'h0000_0080, 1, 0, 16'h0302, 0);
    // R4 masked uncorrectable
    unc_mask = 32'h0002_0000;
    send("R4", 32'h0002_0000, 0, 0, 16'h0401, 0);
    unc_mask = 0;
    // R5 fatal needs serr or fatal enable
    cfg(0, 1, 1, 0, 1);
    send("R5", 32'h0000_0020, 0, 0, 16'h0501, 0);
    cfg(0, 1, 0, 1, 1);
    send("R5", 32'h0000_4000, 0, 0, 16'h0502, 0);
    // R6 UR: serr rescues uncorrectable path, not advisory path
    cfg(1, 1, 0, 0, 0);
    send("R6", 32'h0010_0000, 0, 0, 16'h0601, 0);
    send("R6", 32'h0010_0000, 0, 1, 16'h0602, 0);
    // R7 advisory with uncorrectable bit masked
    cfg(0, 1, 1, 1, 1); unc_mask = 32'h0000_8000;
    send("R7", 32'h0000_8000, 0, 1, 16'h0701, 0);
    unc_mask = 0;
    send("R7", 32'h0000_8000, 0, 1, 16'h0702, 0);
    // R8 overflow follow-up
    send("R8", 32'h0000_1000, 0, 0, 16'h0801, 1);
    // R10 clear with set in same cycle
    clr_cor = 16'hFFFF; clr_dev = 4'hF; clr_unc = 32'hFFFF_FFFF;
    send("R10", 32'h0000_0001, 1, 0, 16'h0A01, 0);

    // R9 random mix
    for (int k = 0; k < 600; k++) begin
      int kind = $urandom % 8;
      logic [31:0] st;
      bit corr = $urandom % 3 == 0;
      if (kind == 0) st = 0;
      else if (kind == 1) st = $urandom;
      else if (kind == 2) st = 32'h1 << ($urandom % 32);
      else begin
        int b;
        do b = $urandom % 32; while (!supported(b, corr));
        st = 32'h1 << b;
      end
      cfg($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
      sev_reg_use = $urandom % 2; unc_sev = $urandom;
      unc_mask = ($urandom % 2) ? $urandom : 0;
      cor_mask = ($urandom % 2) ? 16'($urandom) : 0;
      if ($urandom % 8 == 0) begin
        clr_dev = 4'($urandom); clr_cor = 16'($urandom); clr_unc = $urandom;
      end
      send("R9", st, corr, $urandom % 2, 16'($urandom), $urandom % 4 == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule